// File: doc/BRIEF.md
# Overridable GPIO Port

This block is one 8-bit general-purpose I/O port in which any pin can be taken over by on-chip peripheral logic. Each pin has a port output bit and a direction bit held in registers. It also has four override pairs driven by peripherals, each an enable plus a value: one for the pull-up, one for the direction, one for the driven value and one for the digital input buffer. When an override enable is high, its value replaces the setting the registers would produce. When it is low, the register path decides. The block drives the pad controls: output enable, output value, pull-up enable and input enable.

Pad inputs are returned in two forms. A registered pin value passes through a two-flop synchronizer and is masked by the input enable. A raw copy goes straight back to the peripherals, for signals such as counter clocks or analog-channel selection. Software-side access uses a small write port that selects the output register, the direction register or a toggle action on the output register.

Typical uses are as follows. A debug interface forces the pull-up on, the input buffer off and the direction to input on its clock, select and data-in pins, and drives its data-out pin only while shifting. An external-memory controller forces its three strobe pins to drive with the pull-up off. An asynchronous timer detaches its two crystal pins completely. A serial receiver forces its pin to input while the port bit keeps control of the pull-up. A compare-match output replaces only the driven value, so the direction bit must still be set. Analog-only pins leave all enables low. The block has no state machine: every output is either a register or a per-pin multiplexer.

Top module: `gpio_ovr_port`

## Requirements
- R1: pad_oe[i] equals ovr_dir_val[i] when ovr_dir_en[i] is 1, otherwise the direction register bit i (1 = drive).
- R2: pad_out[i] equals ovr_out_val[i] when ovr_out_en[i] is 1, otherwise port output register bit i.
- R3: pad_pu[i] equals ovr_pu_val[i] when ovr_pu_en[i] is 1; otherwise it is 1 exactly when pad_oe[i] is 0, port output bit i is 1 and pu_disable is 0.
- R4: pad_ie[i] equals ovr_die_val[i] when ovr_die_en[i] is 1, otherwise 1.
- R5: pin_q holds pad_in AND pad_ie as sampled two rising clock edges earlier; it is 0 during reset.
- R6: With wr_en high, wr_sel 0 loads wr_data into the port output register and wr_sel 1 loads it into the direction register, both visible on the next cycle; both registers reset to 0.
- R7: With wr_en high and wr_sel 2, each port output bit whose wr_data bit is 1 inverts, and bits whose wr_data bit is 0 keep their value.
- R8: Overrides act combinationally and are honoured while rst_n is low; a pull-up override held during reset keeps pad_pu high.
- R9: An output-value override alone does not enable the driver: with the direction register bit 0 and no direction override, pad_oe stays 0 whatever ovr_out_en is.
- R10: alt_in equals pad_in in the same cycle, independent of pad_ie.
- R11: With wr_en high and wr_sel 3, neither register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 output reg, 1 direction reg, 2 toggle, 3 none |
| wr_data | input | 8 | Write data |
| pu_disable | input | 1 | Global pull-up disable |
| ovr_pu_en | input | 8 | Pull-up override enables |
| ovr_pu_val | input | 8 | Pull-up override values |
| ovr_dir_en | input | 8 | Direction override enables |
| ovr_dir_val | input | 8 | Direction override values |
| ovr_out_en | input | 8 | Output value override enables |
| ovr_out_val | input | 8 | Output value override values |
| ovr_die_en | input | 8 | Input-enable override enables |
| ovr_die_val | input | 8 | Input-enable override values |
| pad_in | input | 8 | Pad input levels |
| port_q | output | 8 | Port output register |
| dir_q | output | 8 | Direction register |
| pin_q | output | 8 | Synchronized, masked pin levels |
| alt_in | output | 8 | Raw pad levels to peripherals |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_ie | output | 8 | Pad digital input enable |

## Verification
The hardest case to reach from the ports is the interaction between a forced direction and the register-derived pull-up. In that case the direction register says drive, the override says input, and the pull-up must follow the port bit. A second hard case is the pull-up override honoured while reset is held. The stimulus sets those overrides while rst_n is low. It then emulates the receiver, debug, memory-strobe, crystal and compare-output pin patterns with the registers holding conflicting values. After that it runs random mixes of overrides, writes and toggles against a behavioural model compared every cycle.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;
    typedef enum logic [1:0] {
        WSEL_OUT  = 2'd0,
        WSEL_DIR  = 2'd1,
        WSEL_TOG  = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_ovr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  wsel_e        wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] port_q,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] port_nxt;
    logic [W-1:0] dir_nxt;

    always_comb begin
        port_nxt = port_q;
        dir_nxt  = dir_q;
        if (wr_en) begin
            unique case (wr_sel)
                WSEL_OUT:  port_nxt = wr_data;
                WSEL_DIR:  dir_nxt  = wr_data;
                WSEL_TOG:  port_nxt = port_q ^ wr_data;
                WSEL_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            dir_q  <= '0;
        end else begin
            port_q <= port_nxt;
            dir_q  <= dir_nxt;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[s] <= '0;
            end else begin
                stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux (
    input  logic dir_bit,
    input  logic port_bit,
    input  logic pu_off,
    input  logic pu_en,
    input  logic pu_val,
    input  logic dir_en,
    input  logic dir_val,
    input  logic out_en,
    input  logic out_val,
    input  logic die_en,
    input  logic die_val,
    output logic oe,
    output logic out,
    output logic pu,
    output logic ie
);
    logic pu_reg_path;

    always_comb begin
        oe          = dir_en ? dir_val : dir_bit;
        out         = out_en ? out_val : port_bit;
        pu_reg_path = !oe && port_bit && !pu_off;
        pu          = pu_en ? pu_val : pu_reg_path;
        ie          = die_en ? die_val : 1'b1;
    end
endmodule

// File: rtl/gpio_ovr_port.sv
`timescale 1ns/1ps
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int W        = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         pu_disable,
    input  logic [W-1:0] ovr_pu_en,
    input  logic [W-1:0] ovr_pu_val,
    input  logic [W-1:0] ovr_dir_en,
    input  logic [W-1:0] ovr_dir_val,
    input  logic [W-1:0] ovr_out_en,
    input  logic [W-1:0] ovr_out_val,
    input  logic [W-1:0] ovr_die_en,
    input  logic [W-1:0] ovr_die_val,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] port_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pin_q,
    output logic [W-1:0] alt_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_ie
);
    wsel_e        sel_e;
    logic [W-1:0] gated_in;

    assign sel_e = wsel_e'(wr_sel);

    gpio_port_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel_e),
        .wr_data (wr_data),
        .port_q  (port_q),
        .dir_q   (dir_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_mux u_mux (
            .dir_bit  (dir_q[i]),
            .port_bit (port_q[i]),
            .pu_off   (pu_disable),
            .pu_en    (ovr_pu_en[i]),
            .pu_val   (ovr_pu_val[i]),
            .dir_en   (ovr_dir_en[i]),
            .dir_val  (ovr_dir_val[i]),
            .out_en   (ovr_out_en[i]),
            .out_val  (ovr_out_val[i]),
            .die_en   (ovr_die_en[i]),
            .die_val  (ovr_die_val[i]),
            .oe       (pad_oe[i]),
            .out      (pad_out[i]),
            .pu       (pad_pu[i]),
            .ie       (pad_ie[i])
        );
    end

    assign gated_in = pad_in & pad_ie;
    assign alt_in   = pad_in;

    gpio_in_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gated_in),
        .q     (pin_q)
    );
endmodule

// File: rtl/gpio_ovr_port_chk.sv
`timescale 1ns/1ps
module gpio_ovr_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] ovr_dir_en,
    input logic [W-1:0] ovr_dir_val,
    input logic [W-1:0] ovr_out_en,
    input logic [W-1:0] ovr_out_val,
    input logic [W-1:0] ovr_die_en,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] port_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] pin_q,
    input logic [W-1:0] alt_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_ie
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_dir_override_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ ovr_dir_val) & ovr_dir_en) == '0);

    assert_out_override_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ ovr_out_val) & ovr_out_en) == '0);

    assert_ie_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (~ovr_die_en & ~pad_ie) == '0);

    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> pin_q == $past(pad_in & pad_ie, 2));

    assert_load_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> port_q == $past(wr_data));

    assert_load_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> dir_q == $past(wr_data));

    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> port_q == ($past(port_q) ^ $past(wr_data)));

    assert_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q & ~ovr_dir_en) == '0);

    assert_raw_alt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alt_in == pad_in);

    assert_idle_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(port_q) && $stable(dir_q)));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_ovr_port_bench.sv
`timescale 1ns/1ps
module gpio_ovr_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = '0;
    logic       pu_disable = 1'b0;
    logic [7:0] ovr_pu_en = '0, ovr_pu_val = '0, ovr_dir_en = '0, ovr_dir_val = '0;
    logic [7:0] ovr_out_en = '0, ovr_out_val = '0, ovr_die_en = '0, ovr_die_val = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] port_q, dir_q, pin_q, alt_in, pad_oe, pad_out, pad_pu, pad_ie;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_ovr_port u_gpio_ovr_port (.*);

    // behavioural reference state
    logic [7:0] m_port = '0, m_dir = '0;
    logic [7:0] m_hist [$];

    function automatic logic [7:0] f_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ovr_dir_en[i] ? ovr_dir_val[i] : m_dir[i];
        return r;
    endfunction
    function automatic logic [7:0] f_out();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ovr_out_en[i] ? ovr_out_val[i] : m_port[i];
        return r;
    endfunction
    function automatic logic [7:0] f_pu();
        logic [7:0] r, oe;
        oe = f_oe();
        for (int i = 0; i < 8; i++)
            if (ovr_pu_en[i]) r[i] = ovr_pu_val[i];
            else r[i] = (oe[i] == 1'b0) && (m_port[i] == 1'b1) && !pu_disable;
        return r;
    endfunction
    function automatic logic [7:0] f_ie();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ovr_die_en[i] ? ovr_die_val[i] : 1'b1;
        return r;
    endfunction
    function automatic logic [7:0] f_pin();
        if (m_hist.size() < 2) return 8'h00;
        return m_hist[0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_port <= '0;
            m_dir  <= '0;
            m_hist.delete();
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_port <= wr_data;
                    2'd1: m_dir  <= wr_data;
                    2'd2: for (int i = 0; i < 8; i++) if (wr_data[i]) m_port[i] <= ~m_port[i];
                    default: ;
                endcase
            end
            m_hist.push_back(pad_in & f_ie());
            if (m_hist.size() > 2) void'(m_hist.pop_front());
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 pad_oe", pad_oe, f_oe());
        chk("R2 pad_out", pad_out, f_out());
        chk("R3 pad_pu", pad_pu, f_pu());
        chk("R4 pad_ie", pad_ie, f_ie());
        chk("R5 pin_q", pin_q, f_pin());
        chk("R6 port_q", port_q, m_port);
        chk("R6 dir_q", dir_q, m_dir);
        chk("R10 alt_in", alt_in, pad_in);
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic clear_ovr();
        ovr_pu_en = '0; ovr_pu_val = '0; ovr_dir_en = '0; ovr_dir_val = '0;
        ovr_out_en = '0; ovr_out_val = '0; ovr_die_en = '0; ovr_die_val = '0;
    endtask

    initial begin
        // R8: debug-style pins 7,5,4 forced during reset
        ovr_pu_en = 8'hB0; ovr_pu_val = 8'hB0; ovr_dir_en = 8'hB0;
        ovr_die_en = 8'hB0; pad_in = 8'hFF;
        cyc(3);
        chk("R8 pull-up held in reset", pad_pu, 8'hB0);
        chk("R8 input enable in reset", pad_ie, 8'h4F);
        chk("R5 pin_q zero in reset", pin_q, 8'h00);
        chk("R6 port_q reset", port_q, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        cyc(3);
        chk("R5 masked pins read 0", pin_q, 8'h4F);

        // data-out pin 6: drives only while shifting
        ovr_dir_en[6] = 1'b1; ovr_out_en[6] = 1'b1; ovr_out_val[6] = 1'b1;
        cyc();
        chk("R1 data-out idle tri-state", pad_oe & 8'h40, 8'h00);
        ovr_dir_val[6] = 1'b1;
        cyc();
        chk("R1 data-out shifting drives", pad_oe & 8'h40, 8'h40);
        clear_ovr();

        // receiver pin 0: forced input, pull-up from port bit
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h01);
        ovr_dir_en = 8'h01;
        cyc();
        chk("R3 receiver pull-up via port bit", pad_pu, 8'h01);
        chk("R1 receiver forced input", pad_oe, 8'hFE);
        pu_disable = 1'b1;
        cyc();
        chk("R3 global disable", pad_pu, 8'h00);
        pu_disable = 1'b0;
        clear_ovr();

        // memory strobes pins 2..0, crystal pins 4,3
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        ovr_pu_en = 8'h1F; ovr_dir_en = 8'h1F; ovr_dir_val = 8'h07;
        ovr_out_en = 8'h07; ovr_out_val = 8'h05; ovr_die_en = 8'h18;
        cyc();
        chk("R3 strobe and crystal pull-ups off", pad_pu, 8'hE0);
        chk("R2 strobe values", pad_out, 8'hFD);
        chk("R4 crystal inputs off", pad_ie, 8'hE7);
        clear_ovr();

        // compare output pin 5 needs direction bit
        wr(2'd0, 8'h00);
        ovr_out_en = 8'h20; ovr_out_val = 8'h20;
        cyc();
        chk("R9 value override alone does not drive", pad_oe, 8'h00);
        wr(2'd1, 8'h20);
        chk("R9 driven once direction set", pad_oe & pad_out, 8'h20);
        clear_ovr();

        // toggle and ignored select
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'h0F);
        chk("R7 toggle", port_q, 8'hAA);
        wr(2'd3, 8'h33);
        chk("R11 idle select port", port_q, 8'hAA);
        chk("R11 idle select dir", dir_q, 8'h20);

        // random mix, compared every cycle
        for (int n = 0; n < 400; n++) begin
            ovr_pu_en = 8'($urandom); ovr_pu_val = 8'($urandom);
            ovr_dir_en = 8'($urandom); ovr_dir_val = 8'($urandom);
            ovr_out_en = 8'($urandom); ovr_out_val = 8'($urandom);
            ovr_die_en = 8'($urandom); ovr_die_val = 8'($urandom);
            pad_in = 8'($urandom); pu_disable = ($urandom % 4) == 0;
            wr_en = $urandom % 2; wr_sel = 2'($urandom); wr_data = 8'($urandom);
            cyc();
        end
        wr_en = 1'b0;
        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule